// File: doc/BRIEF.md
# Successive-Approximation ADC Sample Sequencer

This block is the host-side sequencer for a 16-bit successive-approximation converter that returns its result over a serial line. It runs a fixed sample cycle, counted in system clocks. At the start of each cycle it raises a convert strobe, which freezes the analog input. It holds the strobe high for the full conversion time and then drops it. Only after that fall does it burst a serial clock of exactly one pulse per result bit. The word is shifted in most significant bit first, and the bits are sampled on the falling serial-clock edges.

Once the last bit has been sampled, the word is copied to a parallel output register and a valid strobe pulses for a single system clock. The cycle length, the conversion wait and the serial half-period are parameters given in system clocks. The parameter set is rejected at elaboration in two cases: the burst cannot finish inside the acquisition window, or the resulting serial clock would be faster than the converter allows.

Top module: `sar_readout_ctrl`

## Requirements
- R1: The convert strobe `adc_cnv` is high for exactly `CONV_CLKS` system clocks and then low for exactly `CYCLE_CLKS - CONV_CLKS` system clocks, so one sample is taken every `CYCLE_CLKS` clocks (defaults 320 and 400 at 200 MHz, giving 1.6 us and 2 us).
- R2: The serial clock `adc_sck` idles low and is never high while `adc_cnv` is high.
- R3: Between a fall of `adc_cnv` and its next rise, `adc_sck` completes exactly `DATA_W` (16) high pulses, and the whole burst ends before that rise.
- R4: Within a burst, every high phase of `adc_sck` lasts `SCK_HALF` system clocks, and every low phase between two pulses lasts `SCK_HALF` system clocks.
- R5: `adc_sdo` is sampled at each falling edge of `adc_sck`. The first bit sampled is placed at bit `DATA_W-1` of `sample_data` (MSB first), and the last bit sampled is placed at bit 0.
- R6: `sample_valid` goes high for exactly one system clock per burst, in the clock in which the new word appears on `sample_data`. At all other times `sample_data` holds its value.
- R7: While reset is asserted, `adc_cnv`, `adc_sck` and `sample_valid` are low and `sample_data` is zero.
- R8: The serial clock period, `2*SCK_HALF*CLK_PERIOD_PS`, is never shorter than `SCK_MIN_PS` (15 ns by default). Parameter sets that break this limit, or that do not fit the burst inside the acquisition window, fail elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| adc_sdo | input | 1 | Serial result bit from the converter |
| adc_cnv | output | 1 | Convert strobe; a rising edge starts a conversion |
| adc_sck | output | 1 | Serial clock to the converter, idles low |
| sample_data | output | DATA_W | Last complete conversion result |
| sample_valid | output | 1 | One-clock pulse when `sample_data` is updated |

## Verification
The bench attacks the all-zeros and all-ones patterns, the two single-bit patterns at either end of the word, and alternating bits, followed by random words. With these patterns a reversed shift order or an off-by-one bit count produces a visibly wrong word. It measures every serial-clock phase and counts the pulses in each acquisition window. This exposes two kinds of fault: a divider that is one clock off, and a burst that leaks one pulse too many or too few or runs into the next conversion. It also watches for serial-clock activity while the strobe is high, which is what a sequencer that started the burst early would produce. It checks that the valid pulse is a single clock long and that the output word never moves between pulses, which catches a register that tracks the shifter directly.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    BURST_IDLE = 1'b0,
    BURST_RUN  = 1'b1
  } burst_state_e;

  // System clocks from the fall of the convert strobe to the last
  // falling serial-clock edge: one launch clock plus two phases per bit.
  function automatic int burst_clks(input int data_w, input int half);
    return 1 + 2 * half * data_w;
  endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
  parameter int CYCLE_CLKS = 400,
  parameter int CONV_CLKS  = 320
) (
  input  logic clk,
  input  logic rst_n,
  output logic cnv_o,
  output logic go_o
);

  localparam int CW = $clog2(CYCLE_CLKS);
  localparam logic [CW-1:0] LAST_CNT = CW'(CYCLE_CLKS - 1);
  localparam logic [CW-1:0] CONV_CNT = CW'(CONV_CLKS);

  logic [CW-1:0] cyc_q, cyc_n;
  logic          cnv_q, cnv_n;
  logic          go_q, go_n;

  always_comb begin
    cyc_n = (cyc_q == LAST_CNT) ? '0 : cyc_q + 1'b1;
    cnv_n = (cyc_q < CONV_CNT);
    go_n  = (cyc_q == CONV_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      cnv_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      cyc_q <= cyc_n;
      cnv_q <= cnv_n;
      go_q  <= go_n;
    end
  end

  assign cnv_o = cnv_q;
  assign go_o  = go_q;

endmodule

// File: rtl/sar_sck_gen.sv
module sar_sck_gen
  import sar_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic sck_o,
  output logic smp_o,
  output logic last_o
);

  localparam int HW = $clog2(SCK_HALF + 1);
  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [HW-1:0] HALF_END = HW'(SCK_HALF - 1);
  localparam logic [BW-1:0] BIT_END  = BW'(DATA_W - 1);

  burst_state_e  st_q, st_n;
  logic [HW-1:0] half_q, half_n;
  logic [BW-1:0] bit_q, bit_n;
  logic          sck_q, sck_n;
  logic          smp, last;

  always_comb begin
    st_n   = st_q;
    half_n = half_q;
    bit_n  = bit_q;
    sck_n  = sck_q;
    smp    = 1'b0;
    last   = 1'b0;
    if (st_q == BURST_IDLE) begin
      if (go_i) begin
        st_n   = BURST_RUN;
        half_n = '0;
        bit_n  = '0;
        sck_n  = 1'b0;
      end
    end else if (half_q == HALF_END) begin
      half_n = '0;
      sck_n  = ~sck_q;
      if (sck_q) begin
        smp = 1'b1;
        if (bit_q == BIT_END) begin
          last = 1'b1;
          st_n = BURST_IDLE;
        end else begin
          bit_n = bit_q + 1'b1;
        end
      end
    end else begin
      half_n = half_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BURST_IDLE;
      half_q <= '0;
      bit_q  <= '0;
      sck_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      half_q <= half_n;
      bit_q  <= bit_n;
      sck_q  <= sck_n;
    end
  end

  assign sck_o  = sck_q;
  assign smp_o  = smp;
  assign last_o = last;

endmodule

// File: rtl/sar_shift_capture.sv
module sar_shift_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdo_i,
  input  logic              smp_i,
  input  logic              last_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] shf_q, shf_n;
  logic [DATA_W-1:0] out_q, out_n;
  logic              vld_q, vld_n;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = {shf_q[DATA_W-2:0], sdo_i};
    shf_n   = smp_i ? shifted : shf_q;
    out_n   = (smp_i && last_i) ? shifted : out_q;
    vld_n   = smp_i && last_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (smp_i) shf_q <= shf_n;
      out_q <= out_n;
      vld_q <= vld_n;
    end
  end

  assign data_o  = out_q;
  assign valid_o = vld_q;

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int CYCLE_CLKS    = 400,
  parameter int CONV_CLKS     = 320,
  parameter int SCK_HALF      = 2,
  parameter int SCK_MIN_PS    = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_sdo,
  output logic              adc_cnv,
  output logic              adc_sck,
  output logic [DATA_W-1:0] sample_data,
  output logic              sample_valid
);

  localparam int ACQ_CLKS      = CYCLE_CLKS - CONV_CLKS;
  localparam int BURST_CLKS    = burst_clks(DATA_W, SCK_HALF);
  localparam int SCK_PERIOD_PS = 2 * SCK_HALF * CLK_PERIOD_PS;

  // R8: reject parameter sets that break the serial timing limits
  if (BURST_CLKS >= ACQ_CLKS) begin : g_burst_too_long
    $error("serial burst of %0d clocks does not fit %0d acquisition clocks",
           BURST_CLKS, ACQ_CLKS);
  end
  if (SCK_PERIOD_PS < SCK_MIN_PS) begin : g_sck_too_fast
    $error("serial clock period %0d ps below minimum %0d ps",
           SCK_PERIOD_PS, SCK_MIN_PS);
  end

  logic rst_meta_q, rst_sync_q;
  logic go, smp, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sar_seq_timer #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .CONV_CLKS  (CONV_CLKS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .cnv_o (adc_cnv),
    .go_o  (go)
  );

  sar_sck_gen #(
    .DATA_W   (DATA_W),
    .SCK_HALF (SCK_HALF)
  ) u_sck (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .go_i   (go),
    .sck_o  (adc_sck),
    .smp_o  (smp),
    .last_o (last)
  );

  sar_shift_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .sdo_i   (adc_sdo),
    .smp_i   (smp),
    .last_i  (last),
    .data_o  (sample_data),
    .valid_o (sample_valid)
  );

endmodule

// File: rtl/sar_readout_ctrl_chk.sv
module sar_readout_ctrl_chk #(
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int CYCLE_CLKS    = 400,
  parameter int CONV_CLKS     = 320,
  parameter int SCK_HALF      = 2,
  parameter int SCK_MIN_PS    = 15000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_cnv,
  input logic              adc_sck,
  input logic [DATA_W-1:0] sample_data,
  input logic              sample_valid
);

  logic        cnv_q, sck_q, seen_q;
  logic [31:0] hi_cnt, lo_cnt, fall_cnt, sck_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q    <= 1'b0;
      sck_q    <= 1'b0;
      seen_q   <= 1'b0;
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      fall_cnt <= '0;
      sck_hi   <= '0;
    end else begin
      cnv_q  <= adc_cnv;
      sck_q  <= adc_sck;
      hi_cnt <= adc_cnv ? hi_cnt + 1 : '0;
      lo_cnt <= adc_cnv ? '0 : lo_cnt + 1;
      sck_hi <= adc_sck ? sck_hi + 1 : '0;
      if (cnv_q && !adc_cnv) begin
        seen_q   <= 1'b1;
        fall_cnt <= '0;
      end else if (sck_q && !adc_sck) begin
        fall_cnt <= fall_cnt + 1;
      end
    end
  end

  initial begin
    a_timing_fit_r8: assert ((1 + 2 * SCK_HALF * DATA_W < CYCLE_CLKS - CONV_CLKS) &&
                             (2 * SCK_HALF * CLK_PERIOD_PS >= SCK_MIN_PS));
  end

  p_conv_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_q && !adc_cnv) |-> (hi_cnt == 32'(CONV_CLKS)));

  p_acq_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !cnv_q && adc_cnv) |-> (lo_cnt == 32'(CYCLE_CLKS - CONV_CLKS)));

  p_quiet_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv |-> !adc_sck);

  p_burst_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !cnv_q && adc_cnv) |-> (fall_cnt == 32'(DATA_W)));

  p_sck_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && !adc_sck) |-> (sck_hi == 32'(SCK_HALF)));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_data) |-> sample_valid);

endmodule

bind sar_readout_ctrl sar_readout_ctrl_chk #(
  .DATA_W        (DATA_W),
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .CYCLE_CLKS    (CYCLE_CLKS),
  .CONV_CLKS     (CONV_CLKS),
  .SCK_HALF      (SCK_HALF),
  .SCK_MIN_PS    (SCK_MIN_PS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adc_cnv      (adc_cnv),
  .adc_sck      (adc_sck),
  .sample_data  (sample_data),
  .sample_valid (sample_valid)
);

// File: tb/sar_readout_ctrl_bench.sv
`timescale 1ns/1ps
module sar_readout_ctrl_bench;

  localparam int DATA_W     = 16;
  localparam int CYCLE_CLKS = 400;
  localparam int CONV_CLKS  = 320;
  localparam int SCK_HALF   = 2;
  localparam int N_SAMPLES  = 30;
  localparam int WD_CLKS    = (N_SAMPLES + 4) * CYCLE_CLKS;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              adc_sdo;
  logic              adc_cnv, adc_sck;
  logic [DATA_W-1:0] sample_data;
  logic              sample_valid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sar_readout_ctrl u_sar_readout_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .adc_sdo      (adc_sdo),
    .adc_cnv      (adc_cnv),
    .adc_sck      (adc_sck),
    .sample_data  (sample_data),
    .sample_valid (sample_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Converter model: word picked per conversion, MSB presented at strobe fall,
  // next bit presented just after each falling serial-clock edge.
  function automatic logic [DATA_W-1:0] pick_word(input int n);
    case (n)
      0:       return '0;
      1:       return '1;
      2:       return 16'h8000;
      3:       return 16'h0001;
      4:       return 16'hAAAA;
      5:       return 16'h5555;
      default: return DATA_W'($urandom);
    endcase
  endfunction

  logic [DATA_W-1:0] cur_word = '0;
  logic [DATA_W-1:0] exp_q[$];
  int                word_n = 0;
  int                bit_idx = -1;

  initial forever begin
    @(posedge adc_cnv);
    cur_word = pick_word(word_n);
    word_n++;
    exp_q.push_back(cur_word);
  end

  initial forever begin
    @(negedge adc_cnv);
    #1;
    adc_sdo = cur_word[DATA_W-1];
    bit_idx = DATA_W - 2;
  end

  initial forever begin
    @(negedge adc_sck);
    #1;
    if (bit_idx >= 0) begin
      adc_sdo = cur_word[bit_idx];
      bit_idx--;
    end
  end

  // Monitor, sampled away from the active edge
  bit      running = 1'b0;
  bit      wd_hit = 1'b0;
  bit      cnv_prev = 1'b0, sck_prev = 1'b0, vld_prev = 1'b0;
  bit      seen_fall = 1'b0, data_moved = 1'b0;
  int      cnv_run = 0, sck_run = 0, falls = 0, n_done = 0, cyc = 0;
  realtime last_rise = -1.0;
  logic [DATA_W-1:0] data_prev = '0;

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      if (cyc > WD_CLKS && !wd_hit) begin
        wd_hit = 1'b1;
        chk(1'b0, "watchdog", cyc, WD_CLKS);
      end
      if (adc_cnv && adc_sck) chk(1'b0, "R2 sck high during conversion", 1, 0);

      if (adc_cnv != cnv_prev) begin
        if (cnv_prev) begin
          chk(cnv_run == CONV_CLKS, "R1 conversion length", cnv_run, CONV_CLKS);
          seen_fall = 1'b1;
          falls = 0;
        end else if (seen_fall) begin
          chk(cnv_run == CYCLE_CLKS - CONV_CLKS, "R1 acquisition length",
              cnv_run, CYCLE_CLKS - CONV_CLKS);
          chk(falls == DATA_W, "R3 pulses per window", falls, DATA_W);
        end
        cnv_run = 1;
      end else cnv_run++;

      if (adc_sck != sck_prev) begin
        if (sck_prev) begin
          chk(sck_run == SCK_HALF, "R4 high phase", sck_run, SCK_HALF);
          falls++;
        end else begin
          if (falls > 0) chk(sck_run == SCK_HALF, "R4 low phase", sck_run, SCK_HALF);
          if (last_rise >= 0.0)
            chk(($realtime - last_rise) >= 15.0, "R8 sck period",
                longint'(($realtime - last_rise) * 1000.0), 15000);
          last_rise = $realtime;
        end
        sck_run = 1;
      end else sck_run++;

      if (vld_prev) chk(!sample_valid, "R6 valid width", sample_valid, 0);
      if (sample_valid) begin
        chk(!data_moved, "R6 hold between pulses", data_moved, 0);
        if (exp_q.size() > 0) begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          chk(sample_data == e, "R5 captured word", sample_data, e);
        end else chk(1'b0, "R5 unexpected word", sample_data, 0);
        n_done++;
        data_moved = 1'b0;
      end else if (sample_data != data_prev) data_moved = 1'b1;

      cnv_prev  = adc_cnv;
      sck_prev  = adc_sck;
      vld_prev  = sample_valid;
      data_prev = sample_data;
    end
  end

  initial begin
    void'($urandom(32'h5a17c3e1));
    adc_sdo = 1'b0;
    rst_n   = 1'b0;
    repeat (4) @(negedge clk);
    chk(!adc_cnv, "R7 cnv in reset", adc_cnv, 0);
    chk(!adc_sck, "R7 sck in reset", adc_sck, 0);
    chk(!sample_valid, "R7 valid in reset", sample_valid, 0);
    chk(sample_data == '0, "R7 data in reset", sample_data, 0);
    rst_n   = 1'b1;
    running = 1'b1;
    while (n_done < N_SAMPLES && !wd_hit) @(negedge clk);
    running = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule